// File: doc/BRIEF.md
# Two-Stage Unlockable Watchdog Timer

This block is a watchdog timer with a small register port. Software programs two 20-bit countdown preloads, a configuration field and a control field. While enabled, the timer counts down in two stages. When the first stage runs out, the block pulses the interrupt that the configuration selects and then loads the second preload. When the second stage runs out, the block either requests a system reset or, if reboot is disabled and free-run is set, starts the first stage again.

The preload registers and the kick register are guarded by a two-value key sequence. A protected access made while the port is unlocked uses up the unlock, so every protected access needs a new sequence. A sticky flag records that a watchdog timeout caused the last reset request. The flag survives the register wipe that goes with that request, and only a power-on reset or a software clear removes it. Decrement ticks come from a prescaler on the input clock, with one divide ratio for the slow scale and one for the fast scale.

The register port writes on one cycle with an address, a data word and byte enables. Reads are combinational and have no side effects.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset, both preloads read 0xFFFFF, the configuration (offset 0x10) and control (offset 0x14) read 0, the kick/status register (offset 0x0C) reads 0, and no output pulses.
- R2: A write to offset 0x0C with byte enables [1:0] set unlocks the port in two steps. Data[15:0]=0x0080 moves it to the half-open state from any state. Data 0x0086 opens it only from the half-open state. Any other value leaves a closed or half-open state unchanged.
- R3: The stage-1 preload (offset 0x00) and the stage-2 preload (offset 0x04) accept a write only while the port is open. They keep the low 20 bits and update only the enabled byte lanes.
- R4: A preload write or a kick write (any value other than 0x0080) made while the port is open closes it again. A second protected write without a new sequence is ignored.
- R5: In the control field, bit 1 is enable, bit 0 is lock and bit 2 is free-run. When enable changes from 0 to 1, stage 1 starts from its preload P1. irq_pulse then follows exactly DIV*(P1+1) cycles after the write edge, where DIV is the active divide ratio.
- R6: The configuration bits [1:0] select the stage-1 event: 0 pulses irq_pulse, 2 pulses smi_pulse, and 1 or 3 pulses nothing. At most one output pulses in any cycle.
- R7: Stage 2 lasts DIV*(P2+1) cycles. If configuration bit 5 is 0 (reboot enabled), expiry pulses reset_req for one cycle and returns all registers to their reset values. The status register then reads 0x1200.
- R8: With configuration bit 5 set and free-run set, stage-2 expiry restarts stage 1 with no reset_req. With bit 5 set and free-run clear, the countdown stops.
- R9: An open kick write with bit 8 set, while enabled, restarts stage 1 from P1 with a fresh prescale period.
- R10: An open kick write with bit 9 or bit 12 set clears the timeout flag. The same write while closed leaves it set.
- R11: Writing enable as 0 stops the countdown, and no further pulses occur.
- R12: Once the lock bit is set, control writes cannot change enable, and lock stays set until a reset or a watchdog reboot.
- R13: Configuration bit 2 selects the fast divide ratio DIV_FAST in place of DIV_SLOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_pulse | output | 1 | One-cycle stage-1 interrupt pulse |
| smi_pulse | output | 1 | One-cycle stage-1 system-management pulse |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with DIV_SLOW=6 and DIV_FAST=2 in place of the defaults of 33000 and 33. With these ratios both stage timeouts, the free-run loop, a ping in the middle of a countdown and a full watchdog reboot all complete within a few tens of cycles, and the exact expiry cycles can be checked against DIV*(P+1). The preload width stays at its default of 20 bits, so the all-ones reset value and the truncation of the upper data bits are checked as they would be in the real configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_PRE1 = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE2 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_KICK = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h14;

    // key values for the guarded sequence
    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    // kick register bit positions
    localparam int BIT_PING  = 8;
    localparam int BIT_CLR_A = 9;
    localparam int BIT_CLR_B = 12;

    localparam logic [DATA_W-1:0] FLAG_WORD = 32'h0000_1200;

    typedef enum logic [1:0] {
        UL_SHUT = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_e;

    typedef enum logic [1:0] {
        EV_IRQ  = 2'd0,
        EV_RSVD = 2'd1,
        EV_SMI  = 2'd2,
        EV_NONE = 2'd3
    } event_sel_e;

    typedef struct packed {
        logic       reboot_off;
        logic       fast;
        event_sel_e evsel;
    } cfg_t;

    typedef struct packed {
        logic free_run;
        logic enable;
        logic locked;
    } ctl_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[5]   = c.reboot_off;
        w[2]   = c.fast;
        w[1:0] = c.evsel;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(input ctl_t c);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = c.locked;
        w[1] = c.enable;
        w[2] = c.free_run;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int PW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg_q,
    output ctl_t              ctl_q,
    output logic [PW-1:0]     pre1_q,
    output logic [PW-1:0]     pre2_q,
    output logic              flag_q,
    output logic              port_open,
    output logic              start_req,
    output logic              stop_req
);

    unlock_e           ul_q;
    logic [15:0]       key;
    logic              kick_wr, kick_act, pre_wr, cfg_wr, ctl_wr;
    logic [DATA_W-1:0] lmask;
    logic [PW-1:0]     pmask;
    logic              unused_bits;

    assign key      = wdata[15:0];
    assign kick_wr  = wr && (addr == OFS_KICK) && (be[1:0] == 2'b11);
    assign kick_act = kick_wr && (ul_q == UL_OPEN) && (key != KEY_FIRST);
    assign pre_wr   = wr && ((addr == OFS_PRE1) || (addr == OFS_PRE2));
    assign cfg_wr   = wr && (addr == OFS_CFG) && be[0];
    assign ctl_wr   = wr && (addr == OFS_CTL) && be[0];
    assign lmask    = lane_mask(be);
    assign pmask    = lmask[PW-1:0];
    assign port_open = (ul_q == UL_OPEN);

    assign unused_bits = ^{lmask[DATA_W-1:PW], wdata[DATA_W-1:PW]};

    assign start_req = (ctl_wr && !ctl_q.locked && wdata[1] && !ctl_q.enable)
                    || (kick_act && wdata[BIT_PING] && ctl_q.enable);
    assign stop_req  = ctl_wr && !ctl_q.locked && !wdata[1];

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            pre1_q <= '1;
            pre2_q <= '1;
            cfg_q  <= '0;
            ctl_q  <= '0;
            ul_q   <= UL_SHUT;
            flag_q <= !rst;
        end else begin
            if (kick_wr) begin
                if (key == KEY_FIRST) begin
                    ul_q <= UL_HALF;
                end else if (key == KEY_SECOND && ul_q == UL_HALF) begin
                    ul_q <= UL_OPEN;
                end else if (ul_q == UL_OPEN) begin
                    ul_q <= UL_SHUT;
                    if (wdata[BIT_CLR_A] || wdata[BIT_CLR_B]) begin
                        flag_q <= 1'b0;
                    end
                end
            end
            if (pre_wr && ul_q == UL_OPEN) begin
                ul_q <= UL_SHUT;
                if (addr == OFS_PRE1) begin
                    pre1_q <= (pre1_q & ~pmask) | (wdata[PW-1:0] & pmask);
                end else begin
                    pre2_q <= (pre2_q & ~pmask) | (wdata[PW-1:0] & pmask);
                end
            end
            if (cfg_wr) begin
                cfg_q.reboot_off <= wdata[5];
                cfg_q.fast       <= wdata[2];
                cfg_q.evsel      <= event_sel_e'(wdata[1:0]);
            end
            if (ctl_wr) begin
                ctl_q.free_run <= wdata[2];
                if (!ctl_q.locked) begin
                    ctl_q.enable <= wdata[1];
                    ctl_q.locked <= wdata[0];
                end
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_PRE1: rdata = {{(DATA_W-PW){1'b0}}, pre1_q};
            OFS_PRE2: rdata = {{(DATA_W-PW){1'b0}}, pre2_q};
            OFS_KICK: rdata = flag_q ? FLAG_WORD : '0;
            OFS_CFG:  rdata = cfg_word(cfg_q);
            OFS_CTL:  rdata = ctl_word(ctl_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV_SLOW = 33000,
    parameter int DIV_FAST = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic fast,
    output logic tick
);

    localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] pcnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    assign tick = run && !restart && (pcnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr
    import wdt_pkg::*;
#(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          tick,
    input  logic [PW-1:0] pre1,
    input  logic [PW-1:0] pre2,
    input  logic          free_run,
    input  logic          reboot_en,
    input  event_sel_e    evsel,
    output logic          running,
    output logic          reboot_now,
    output logic          irq_q,
    output logic          smi_q,
    output logic          rreq_q
);

    logic          second_q;
    logic [PW-1:0] cnt_q;
    logic          expire;

    assign expire     = running && tick && (cnt_q == '0) && !start && !stop;
    assign reboot_now = expire && second_q && reboot_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            second_q <= 1'b0;
            cnt_q    <= '0;
            irq_q    <= 1'b0;
            smi_q    <= 1'b0;
            rreq_q   <= 1'b0;
        end else begin
            irq_q  <= 1'b0;
            smi_q  <= 1'b0;
            rreq_q <= 1'b0;
            if (start) begin
                running  <= 1'b1;
                second_q <= 1'b0;
                cnt_q    <= pre1;
            end else if (stop) begin
                running <= 1'b0;
            end else if (running && tick) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (!second_q) begin
                    second_q <= 1'b1;
                    cnt_q    <= pre2;
                    irq_q    <= (evsel == EV_IRQ);
                    smi_q    <= (evsel == EV_SMI);
                end else if (reboot_en) begin
                    running <= 1'b0;
                    rreq_q  <= 1'b1;
                end else if (free_run) begin
                    second_q <= 1'b0;
                    cnt_q    <= pre1;
                end else begin
                    running <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PW       = 20,
    parameter int DIV_SLOW = 33000,
    parameter int DIV_FAST = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse,
    output logic              smi_pulse,
    output logic              reset_req
);

    cfg_t          cfg_q;
    ctl_t          ctl_q;
    logic [PW-1:0] pre1_q, pre2_q;
    logic          flag_q, port_open, start_req, stop_req;
    logic          running, tick, wipe;
    logic          lock_w, enable_w;

    assign lock_w   = ctl_q.locked;
    assign enable_w = ctl_q.enable;

    wdt_regs #(.PW(PW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wipe      (wipe),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .be        (bus_be),
        .rdata     (bus_rdata),
        .cfg_q     (cfg_q),
        .ctl_q     (ctl_q),
        .pre1_q    (pre1_q),
        .pre2_q    (pre2_q),
        .flag_q    (flag_q),
        .port_open (port_open),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    wdt_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (start_req),
        .fast    (cfg_q.fast),
        .tick    (tick)
    );

    wdt_stage_ctr #(.PW(PW)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .start      (start_req),
        .stop       (stop_req),
        .tick       (tick),
        .pre1       (pre1_q),
        .pre2       (pre2_q),
        .free_run   (ctl_q.free_run),
        .reboot_en  (!cfg_q.reboot_off),
        .evsel      (cfg_q.evsel),
        .running    (running),
        .reboot_now (wipe),
        .irq_q      (irq_pulse),
        .smi_q      (smi_pulse),
        .rreq_q     (reset_req)
    );

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
    import wdt_pkg::*;
#(
    parameter int PW = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              smi,
    input logic              rreq,
    input logic              flag,
    input logic              locked,
    input logic              enable,
    input logic              port_open,
    input logic              running,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PW-1:0]     pre1
);

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq, smi, rreq})); // R6

    AST_RESET_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rreq |=> !rreq); // R7

    AST_FLAG_ON_REBOOT: assert property (@(posedge clk) disable iff (rst)
        rreq |-> flag); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && !rreq) |-> locked); // R12

    AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> (enable == $past(enable))); // R12

    AST_UNLOCK_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PRE1 && port_open) |=> !port_open); // R4

    AST_PRELOAD_GUARDED: assert property (@(posedge clk) disable iff (rst)
        !port_open |=> ($stable(pre1) || rreq)); // R3

    AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(running)); // R5

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq_pulse),
    .smi       (smi_pulse),
    .rreq      (reset_req),
    .flag      (flag_q),
    .locked    (lock_w),
    .enable    (enable_w),
    .port_open (port_open),
    .running   (running),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .pre1      (pre1_q)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
    import wdt_pkg::*;

    localparam int DS = 6;
    localparam int DF = 2;
    localparam int PW = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [BE_W-1:0]   bus_be = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_pulse, smi_pulse, reset_req;

    wdt_two_stage #(.PW(PW), .DIV_SLOW(DS), .DIV_FAST(DF)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reset_req(reset_req)
    );

    always #4 clk = ~clk; // 125 MHz

    int    vectors = 0;
    int    misses  = 0;
    int    cyc     = 0;
    int    last_wr = 0;
    string cur_req = "R1";
    int    irq_q[$];
    int    smi_q[$];
    int    rst_q[$];

    // reference model state
    int m_pre1, m_pre2, m_ul, m_flag, m_roff, m_fast, m_ev, m_en, m_lock, m_free;
    int m_run, m_stage, m_cnt, m_pc;
    bit m_irq, m_smi, m_rreq;

    task automatic m_defaults();
        m_pre1 = 'hFFFFF; m_pre2 = 'hFFFFF; m_ul = 0;
        m_roff = 0; m_fast = 0; m_ev = 0; m_en = 0; m_lock = 0; m_free = 0;
    endtask

    function automatic int exp_rdata(input int a);
        case (a)
            0:  return m_pre1;
            4:  return m_pre2;
            12: return m_flag ? 'h1200 : 0;
            16: return (m_roff << 5) | (m_fast << 2) | m_ev;
            20: return (m_free << 2) | (m_en << 1) | m_lock;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin : model
        int key, div, new_pc, mask, d;
        bit start, stop, tick, kick, act, wipe, cfgw, ctlw, prew;
        m_irq = 0; m_smi = 0; m_rreq = 0;
        if (rst) begin
            m_defaults();
            m_flag = 0; m_run = 0; m_stage = 1; m_cnt = 0; m_pc = 0;
        end else begin
            d     = int'(bus_wdata);
            key   = d & 'hFFFF;
            kick  = bus_wr && bus_addr == 12 && bus_be[1:0] == 2'b11;
            act   = kick && m_ul == 2 && key != 'h80;
            cfgw  = bus_wr && bus_addr == 16 && bus_be[0];
            ctlw  = bus_wr && bus_addr == 20 && bus_be[0];
            prew  = bus_wr && (bus_addr == 0 || bus_addr == 4);
            start = 0; stop = 0; wipe = 0;
            if (ctlw && !m_lock) begin
                if (d[1] && !m_en) start = 1;
                if (!d[1]) stop = 1;
            end
            if (act && d[8] && m_en) start = 1;
            div    = m_fast ? DF : DS;
            tick   = m_run && !start && (m_pc >= div - 1);
            new_pc = (!m_run || start || tick) ? 0 : m_pc + 1;
            if (start) begin
                m_run = 1; m_stage = 1; m_cnt = m_pre1;
            end else if (stop) begin
                m_run = 0;
            end else if (m_run && tick) begin
                if (m_cnt > 0) m_cnt--;
                else if (m_stage == 1) begin
                    m_stage = 2; m_cnt = m_pre2;
                    m_irq = (m_ev == 0); m_smi = (m_ev == 2);
                end else if (!m_roff) begin
                    m_run = 0; m_rreq = 1; wipe = 1;
                end else if (m_free) begin
                    m_stage = 1; m_cnt = m_pre1;
                end else m_run = 0;
            end
            m_pc = new_pc;
            if (wipe) begin
                m_defaults(); m_flag = 1;
            end else begin
                if (kick) begin
                    if (key == 'h80) m_ul = 1;
                    else if (key == 'h86 && m_ul == 1) m_ul = 2;
                    else if (m_ul == 2) begin
                        m_ul = 0;
                        if (d[9] || d[12]) m_flag = 0;
                    end
                end
                if (prew && m_ul == 2) begin
                    m_ul = 0;
                    mask = 0;
                    for (int i = 0; i < 4; i++) if (bus_be[i]) mask |= ('hFF << (8 * i));
                    mask &= 'hFFFFF;
                    if (bus_addr == 0) m_pre1 = (m_pre1 & ~mask) | (d & mask);
                    else               m_pre2 = (m_pre2 & ~mask) | (d & mask);
                end
                if (cfgw) begin
                    m_roff = d[5]; m_fast = d[2]; m_ev = d & 3;
                end
                if (ctlw) begin
                    m_free = d[2];
                    if (!m_lock) begin m_en = d[1]; m_lock = d[0]; end
                end
            end
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        vectors++;
        if (irq_pulse !== m_irq || smi_pulse !== m_smi || reset_req !== m_rreq ||
            bus_rdata !== DATA_W'(exp_rdata(int'(bus_addr)))) begin
            misses++;
            $display("FAIL %s cycle %0d: actual irq=%0b smi=%0b rreq=%0b rdata=%h expected irq=%0b smi=%0b rreq=%0b rdata=%h",
                     cur_req, cyc, irq_pulse, smi_pulse, reset_req, bus_rdata,
                     m_irq, m_smi, m_rreq, exp_rdata(int'(bus_addr)));
        end
        if (irq_pulse === 1'b1) irq_q.push_back(cyc);
        if (smi_pulse === 1'b1) smi_q.push_back(cyc);
        if (reset_req === 1'b1) rst_q.push_back(cyc);
    end

    task automatic chk(input string req, input int act, input int expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input int a, input int d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); bus_be = be;
        @(posedge clk);
        #1 last_wr = cyc;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 v = int'(bus_rdata);
    endtask

    task automatic unlock();
        wr(12, 'h80, 4'b0011);
        wr(12, 'h86, 4'b0011);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_q();
        irq_q.delete(); smi_q.delete(); rst_q.delete();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int v, e;
        idle(3);
        @(negedge clk) rst = 1'b0;

        cur_req = "R1";
        rd(0, v);  chk("R1 preload1 reset", v, 'hFFFFF);
        rd(4, v);  chk("R1 preload2 reset", v, 'hFFFFF);
        rd(16, v); chk("R1 config reset", v, 0);
        rd(20, v); chk("R1 control reset", v, 0);
        rd(12, v); chk("R1 status reset", v, 0);

        cur_req = "R2";
        wr(12, 'h86, 4'b0011);
        wr(0, 5);
        rd(0, v);  chk("R2 second key alone ignored", v, 'hFFFFF);
        cur_req = "R3";
        wr(0, 7);
        rd(0, v);  chk("R3 closed preload write ignored", v, 'hFFFFF);
        unlock(); wr(0, 'hABC12345);
        rd(0, v);  chk("R3 preload truncated to 20 bits", v, 'h12345);
        cur_req = "R4";
        wr(0, 7);
        rd(0, v);  chk("R4 unlock consumed by preload write", v, 'h12345);
        cur_req = "R3";
        unlock(); wr(4, 2);
        unlock(); wr(4, 'h00FF0000, 4'b0100);
        rd(4, v);  chk("R3 byte lane merge", v, 'hF0002);
        unlock(); wr(0, 3);
        unlock(); wr(4, 2);

        cur_req = "R5";
        clear_q();
        wr(20, 'h02); e = last_wr;
        idle(50);
        chk("R5 one irq", irq_q.size(), 1);
        if (irq_q.size() > 0) chk("R5 stage1 timing", irq_q[0] - e, DS * 4);
        cur_req = "R7";
        chk("R7 one reset_req", rst_q.size(), 1);
        if (rst_q.size() > 0) chk("R7 stage2 timing", rst_q[0] - e, DS * 4 + DS * 3);
        rd(12, v); chk("R7 timeout flag set", v, 'h1200);
        rd(20, v); chk("R7 control wiped", v, 0);
        rd(0, v);  chk("R7 preload wiped", v, 'hFFFFF);

        cur_req = "R10";
        wr(12, 'h200, 4'b0011);
        rd(12, v); chk("R10 closed clear ignored", v, 'h1200);
        unlock(); wr(12, 'h200, 4'b0011);
        rd(12, v); chk("R10 bit 9 clears flag", v, 0);

        cur_req = "R8";
        unlock(); wr(0, 2);
        unlock(); wr(4, 1);
        wr(16, 'h26);
        clear_q();
        wr(20, 'h06); e = last_wr;
        idle(20);
        chk("R6 smi count", smi_q.size() >= 2, 1);
        chk("R6 no irq for type 2", irq_q.size(), 0);
        if (smi_q.size() >= 2) begin
            chk("R13 fast stage1 timing", smi_q[0] - e, DF * 3);
            chk("R8 free-run restart timing", smi_q[1] - e, DF * 3 + DF * 2 + DF * 3);
        end
        chk("R8 no reset_req with reboot off", rst_q.size(), 0);

        cur_req = "R11";
        wr(20, 'h00);
        clear_q();
        idle(40);
        chk("R11 stopped no pulses", irq_q.size() + smi_q.size() + rst_q.size(), 0);

        cur_req = "R9";
        wr(16, 'h20);
        clear_q();
        wr(20, 'h02);
        unlock(); wr(12, 'h100, 4'b0011); e = last_wr;
        idle(50);
        chk("R9 one irq", irq_q.size(), 1);
        if (irq_q.size() > 0) chk("R9 ping restart timing", irq_q[0] - e, DS * 3);
        chk("R8 stop without free-run", rst_q.size(), 0);

        cur_req = "R12";
        wr(20, 'h01);
        wr(20, 'h02);
        rd(20, v); chk("R12 enable frozen", v, 'h01);
        wr(20, 'h00);
        rd(20, v); chk("R12 lock sticky", v, 'h01);
        clear_q();
        idle(30);
        chk("R12 locked off no pulses", irq_q.size(), 0);

        cur_req = "R1";
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        rd(20, v); chk("R1 reset clears lock", v, 0);
        rd(12, v); chk("R1 reset clears flag", v, 0);

        cur_req = "R7";
        unlock(); wr(0, 1);
        unlock(); wr(4, 1);
        wr(16, 'h04);
        clear_q();
        wr(20, 'h02); e = last_wr;
        idle(16);
        chk("R7 fast reboot count", rst_q.size(), 1);
        if (rst_q.size() > 0) chk("R13 fast reboot timing", rst_q[0] - e, DF * 2 + DF * 2);
        cur_req = "R10";
        rd(12, v); chk("R10 flag set again", v, 'h1200);
        unlock(); wr(12, 'h1000, 4'b0011);
        rd(12, v); chk("R10 bit 12 clears flag", v, 0);

        cur_req = "R6";
        unlock(); wr(0, 1);
        unlock(); wr(4, 1);
        wr(16, 'h27);
        clear_q();
        wr(20, 'h06);
        idle(30);
        wr(16, 'h25);
        idle(30);
        chk("R6 types 3 and 1 silent", irq_q.size() + smi_q.size() + rst_q.size(), 0);

        idle(4);
        summary();
    end

endmodule